// File: doc/BRIEF.md
# Branch Condition and Program Counter Unit

This unit owns the program counter of a small 16-bit-address processor. Each cycle in which the decoder asserts `step`, it gets the retiring instruction's control-flow kind, its length in words, a 16-bit target address and the four status flags (zero, carry, negative, overflow). From these it computes the next PC. The PC moves sequentially by the instruction length, takes the target when the selected condition holds, or takes a return address.

Subroutine linkage uses a small hardware return stack inside the unit. A call pushes the address of the word after its two-word encoding and jumps. A return pops that address into the PC. Pushing onto a full stack and popping an empty one are both refused and reported on one-cycle error outputs. A halt kind freezes the PC until reset.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pc` is 0x0000 and `halted`, `stk_overflow` and `stk_underflow` are 0.
- R2: A step with kind code 0 (sequential), or with an unused code 10 to 15, sets `pc` to `pc + 1` when `len2` is 0 and to `pc + 2` when `len2` is 1, modulo 2^16. The flags have no effect.
- R3: A step with kind code 1 (unconditional jump) loads `target` into `pc` whatever the flags are.
- R4: Kind code 2 takes the target when `flag_z` is 1. Kind code 3 takes the target when `flag_z` is 0. Otherwise the PC advances as in R2.
- R5: Kind code 4 takes the target when `flag_c` is 1. Kind code 5 takes the target when `flag_n` is 1. Otherwise the PC advances as in R2.
- R6: Kind code 6 (signed greater-or-equal) takes the target exactly when `flag_n` equals `flag_v`. Otherwise the PC advances as in R2.
- R7: Kind code 7 (call) pushes `pc + 2` onto the return stack and loads `target`. Kind code 8 (return) loads the most recently pushed address and removes it. The stack is last-in first-out and holds 8 entries.
- R8: A call while 8 entries are held pulses `stk_overflow` high for one cycle. It leaves `pc` and the stack contents unchanged.
- R9: A return while the stack is empty pulses `stk_underflow` high for one cycle and leaves `pc` unchanged.
- R10: Kind code 9 (halt) sets `halted` and keeps `pc`. After that, every step is ignored until reset.
- R11: In a cycle with `step` low, `pc`, `halted` and the stack do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | An instruction retires this cycle |
| len2 | input | 1 | 1 when the retiring instruction is two words long |
| br_kind | input | 4 | Control-flow kind code (see requirements) |
| target | input | 16 | Branch, jump or call destination |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Signed overflow flag |
| pc | output | 16 | Current program counter |
| halted | output | 1 | PC frozen by a halt |
| stk_overflow | output | 1 | One-cycle pulse: call refused, stack full |
| stk_underflow | output | 1 | One-cycle pulse: return refused, stack empty |

## Verification
Each conditional kind is driven with its deciding flag both set and clear, and with the other flags set so that they would change the outcome if they were wrongly decoded. The signed greater-or-equal kind is run through all four combinations of N and V, which separates an XOR test from a test on N alone. Sequential steps of one and two words, including a wrap past 0xFFFF, separate the two length increments. A run of nested calls to full depth and back out checks last-in-first-out order. One extra call and one extra return then probe the full and empty limits.

// File: rtl/pcu_pkg.sv
// Package: shared types for the program counter unit.
// Assumes: kind codes are fixed by the decoder that drives br_kind.
package pcu_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [3:0] {
        K_SEQ  = 4'd0,
        K_JMP  = 4'd1,
        K_JZ   = 4'd2,
        K_JNZ  = 4'd3,
        K_JC   = 4'd4,
        K_JN   = 4'd5,
        K_JGE  = 4'd6,
        K_CALL = 4'd7,
        K_RET  = 4'd8,
        K_HALT = 4'd9
    } kind_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/pcu_cond_eval.sv
// Module: pcu_cond_eval
// Decides whether a control-flow kind transfers to its target, given the flags.
// Assumes: purely combinational; call, return and halt are handled elsewhere,
// so only unconditional and conditional jumps report "taken" here.
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  logic [3:0] kind,
    input  flags_t     flags,
    output logic       taken
);

    // Select the flag test that belongs to the kind code.
    always_comb begin
        case (kind)
            K_JMP:   taken = 1'b1;
            K_JZ:    taken = flags.z;
            K_JNZ:   taken = ~flags.z;
            K_JC:    taken = flags.c;
            K_JN:    taken = flags.n;
            K_JGE:   taken = ~(flags.n ^ flags.v);
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_ret_stack.sv
// Module: pcu_ret_stack
// Register-based LIFO of return addresses.
// Assumes: caller never asserts push when full or pop when empty (such
// requests are ignored here anyway); push and pop are never both high.
module pcu_ret_stack #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top_data,
    output logic              full,
    output logic              empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign full   = (count_q == CNT_MAX);
    assign empty  = (count_q == '0);
    assign wr_idx = IDX_W'(count_q);
    assign rd_idx = IDX_W'(count_q - 1'b1);

    // Occupancy counter: up on accepted push, down on accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (push && !full)
            count_q <= count_q + 1'b1;
        else if (pop && !empty)
            count_q <= count_q - 1'b1;
    end

    // One storage register per entry, written when it is the next free slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push && !full && (wr_idx == IDX_W'(g)))
                slot_q[g] <= push_data;
        end
    end

    // Present the newest entry; zero when empty.
    always_comb begin
        top_data = empty ? '0 : slot_q[rd_idx];
    end

endmodule

// File: rtl/pcu_next_sel.sv
// Module: pcu_next_sel
// Chooses the next PC and the stack/error/halt actions for one retiring step.
// Assumes: combinational; the caller only commits the results when a step
// is accepted (step high and not halted).
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic [3:0]          kind,
    input  logic                len2,
    input  logic                taken,
    input  logic [ADDR_W_P-1:0] pc_cur,
    input  logic [ADDR_W_P-1:0] target,
    input  logic [ADDR_W_P-1:0] stack_top,
    input  logic                stack_full,
    input  logic                stack_empty,
    output logic [ADDR_W_P-1:0] pc_next,
    output logic [ADDR_W_P-1:0] ret_addr,
    output logic                do_push,
    output logic                do_pop,
    output logic                ovf_evt,
    output logic                unf_evt,
    output logic                halt_evt
);

    logic [ADDR_W_P-1:0] pc_seq;

    // Sequential successor: one or two words ahead, wrapping at the top.
    always_comb begin
        pc_seq   = pc_cur + (len2 ? ADDR_W_P'(2) : ADDR_W_P'(1));
        ret_addr = pc_cur + ADDR_W_P'(2);
    end

    // Per-kind choice of next PC and side actions.
    always_comb begin
        pc_next  = taken ? target : pc_seq;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        ovf_evt  = 1'b0;
        unf_evt  = 1'b0;
        halt_evt = 1'b0;
        case (kind)
            K_CALL: begin
                if (stack_full) begin
                    ovf_evt = 1'b1;
                    pc_next = pc_cur;
                end else begin
                    do_push = 1'b1;
                    pc_next = target;
                end
            end
            K_RET: begin
                if (stack_empty) begin
                    unf_evt = 1'b1;
                    pc_next = pc_cur;
                end else begin
                    do_pop  = 1'b1;
                    pc_next = stack_top;
                end
            end
            K_HALT: begin
                halt_evt = 1'b1;
                pc_next  = pc_cur;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Holds the program counter and advances it once per accepted step, using
// the condition evaluator, the next-PC selector and the return stack.
// Assumes: synchronous active-low reset; inputs are valid whenever step is high.
module pc_sequencer
    import pcu_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    parameter int PC_W        = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            len2,
    input  logic [3:0]      br_kind,
    input  logic [PC_W-1:0] target,
    input  logic            flag_z,
    input  logic            flag_c,
    input  logic            flag_n,
    input  logic            flag_v,
    output logic [PC_W-1:0] pc,
    output logic            halted,
    output logic            stk_overflow,
    output logic            stk_underflow
);

    logic [PC_W-1:0] pc_q;
    logic            halted_q;
    logic            ovf_q;
    logic            unf_q;
    logic            accept;
    logic            taken;
    flags_t          flags;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] stack_top;
    logic            stack_full;
    logic            stack_empty;
    logic            do_push;
    logic            do_pop;
    logic            ovf_evt;
    logic            unf_evt;
    logic            halt_evt;

    assign flags  = '{z: flag_z, c: flag_c, n: flag_n, v: flag_v};
    assign accept = step && !halted_q;

    pcu_cond_eval u_cond (
        .kind  (br_kind),
        .flags (flags),
        .taken (taken)
    );

    pcu_next_sel #(.ADDR_W_P(PC_W)) u_sel (
        .kind        (br_kind),
        .len2        (len2),
        .taken       (taken),
        .pc_cur      (pc_q),
        .target      (target),
        .stack_top   (stack_top),
        .stack_full  (stack_full),
        .stack_empty (stack_empty),
        .pc_next     (pc_next),
        .ret_addr    (ret_addr),
        .do_push     (do_push),
        .do_pop      (do_pop),
        .ovf_evt     (ovf_evt),
        .unf_evt     (unf_evt),
        .halt_evt    (halt_evt)
    );

    pcu_ret_stack #(.DEPTH(STACK_DEPTH), .DATA_W(PC_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && do_push),
        .pop       (accept && do_pop),
        .push_data (ret_addr),
        .top_data  (stack_top),
        .full      (stack_full),
        .empty     (stack_empty)
    );

    // Program counter register: loads the selected address on an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (accept)
            pc_q <= pc_next;
    end

    // Halt latch: set by a halt step, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted_q <= 1'b0;
        else if (accept && halt_evt)
            halted_q <= 1'b1;
    end

    // Stack error pulses, one cycle after the refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= accept && ovf_evt;
            unf_q <= accept && unf_evt;
        end
    end

    assign pc            = pc_q;
    assign halted        = halted_q;
    assign stk_overflow  = ovf_q;
    assign stk_underflow = unf_q;

endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Temporal properties on the ports of pc_sequencer, bound to every instance.
// Keeps its own occupancy count of the return stack from the port activity.
module pcu_checker #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step,
    input logic            len2,
    input logic [3:0]      br_kind,
    input logic [PC_W-1:0] target,
    input logic [PC_W-1:0] pc,
    input logic            halted,
    input logic            stk_overflow,
    input logic            stk_underflow
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] depth_q;
    logic          live;

    assign live = step && !halted;

    // Shadow occupancy derived from accepted calls and returns.
    always_ff @(posedge clk) begin
        if (!rst_n)
            depth_q <= '0;
        else if (live && br_kind == 4'd7 && depth_q != CW'(DEPTH))
            depth_q <= depth_q + 1'b1;
        else if (live && br_kind == 4'd8 && depth_q != '0)
            depth_q <= depth_q - 1'b1;
    end

    a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (live && br_kind == 4'd0) |=> (pc == $past(pc) + ($past(len2) ? 16'd2 : 16'd1)));

    a_r3_jmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (live && br_kind == 4'd1) |=> (pc == $past(target)));

    a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (live && br_kind == 4'd7 && depth_q == CW'(DEPTH)) |=> (stk_overflow && $stable(pc)));

    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (live && br_kind == 4'd8 && depth_q == '0) |=> (stk_underflow && $stable(pc)));

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pc) && $stable(halted)));

endmodule

bind pc_sequencer pcu_checker #(.DEPTH(STACK_DEPTH), .PC_W(PC_W)) u_pcu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step),
    .len2          (len2),
    .br_kind       (br_kind),
    .target        (target),
    .pc            (pc),
    .halted        (halted),
    .stk_overflow  (stk_overflow),
    .stk_underflow (stk_underflow)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        len2 = 1'b0;
    logic [3:0]  br_kind = 4'd0;
    logic [15:0] target = 16'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic        flag_n = 1'b0;
    logic        flag_v = 1'b0;
    logic [15:0] pc;
    logic        halted;
    logic        stk_overflow;
    logic        stk_underflow;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .step(step), .len2(len2), .br_kind(br_kind),
        .target(target), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
        .flag_v(flag_v), .pc(pc), .halted(halted),
        .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
    );

    // Vector: {kind[4], len2, flags z c n v [4], target[16], expected pc[16]}
    localparam int NV = 17;
    localparam logic [40:0] VEC [NV] = '{
        {4'd0, 1'b0, 4'b1111, 16'h9999, 16'h0001},  // R2 one word, flags ignored
        {4'd0, 1'b1, 4'b0000, 16'h9999, 16'h0003},  // R2 two words
        {4'd1, 1'b1, 4'b0000, 16'h1000, 16'h1000},  // R3 jump, flags clear
        {4'd2, 1'b1, 4'b1000, 16'h2000, 16'h2000},  // R4 JZ taken
        {4'd2, 1'b1, 4'b0111, 16'h3000, 16'h2002},  // R4 JZ not taken
        {4'd3, 1'b1, 4'b0111, 16'h3000, 16'h3000},  // R4 JNZ taken
        {4'd3, 1'b1, 4'b1000, 16'h4000, 16'h3002},  // R4 JNZ not taken
        {4'd4, 1'b1, 4'b0100, 16'h4000, 16'h4000},  // R5 JC taken
        {4'd4, 1'b1, 4'b1011, 16'h5000, 16'h4002},  // R5 JC not taken
        {4'd5, 1'b1, 4'b0010, 16'h5000, 16'h5000},  // R5 JN taken
        {4'd5, 1'b1, 4'b1101, 16'h6000, 16'h5002},  // R5 JN not taken
        {4'd6, 1'b1, 4'b0000, 16'h6000, 16'h6000},  // R6 N=0 V=0 taken
        {4'd6, 1'b1, 4'b0011, 16'h7000, 16'h7000},  // R6 N=1 V=1 taken
        {4'd6, 1'b1, 4'b0010, 16'h8000, 16'h7002},  // R6 N=1 V=0 not taken
        {4'd6, 1'b1, 4'b0001, 16'h8000, 16'h7004},  // R6 N=0 V=1 not taken
        {4'd1, 1'b0, 4'b1111, 16'hFFFF, 16'hFFFF},  // R3 jump, flags set
        {4'd12, 1'b0, 4'b1111, 16'h1234, 16'h0000}  // R2 unused code, wrap
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one step on a falling edge; sample after the following rising edge.
    task automatic do_step(input logic [3:0] k, input logic l2, input logic [3:0] f,
                           input logic [15:0] t);
        @(negedge clk);
        step = 1'b1; br_kind = k; len2 = l2; target = t;
        {flag_z, flag_c, flag_n, flag_v} = f;
        @(negedge clk);
        step = 1'b0;
    endtask

    logic [15:0] model [8];
    logic [15:0] here;

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pc during reset", pc, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pc after reset", pc, 16'h0000);
        check("R1 flags after reset", {13'd0, halted, stk_overflow, stk_underflow}, 16'h0000);

        // Table walk over sequential and branch kinds.
        for (int i = 0; i < NV; i++) begin
            do_step(VEC[i][40:37], VEC[i][36], VEC[i][35:32], VEC[i][31:16]);
            check($sformatf("R2-6 vector %0d", i), pc, VEC[i][15:0]);
        end

        // R11: no step, no change.
        do_step(4'd1, 1'b0, 4'b0000, 16'h0100);
        @(negedge clk);
        @(negedge clk);
        check("R11 idle hold", pc, 16'h0100);

        // R7 nested call and return.
        do_step(4'd7, 1'b1, 4'b0000, 16'h0200);
        check("R7 call 1", pc, 16'h0200);
        do_step(4'd7, 1'b1, 4'b0000, 16'h0300);
        check("R7 call 2", pc, 16'h0300);
        do_step(4'd8, 1'b0, 4'b0000, 16'hAAAA);
        check("R7 return 1", pc, 16'h0202);
        do_step(4'd8, 1'b0, 4'b0000, 16'hAAAA);
        check("R7 return 2", pc, 16'h0102);

        // R9 return on empty stack.
        do_step(4'd8, 1'b0, 4'b0000, 16'hAAAA);
        check("R9 underflow pulse", {15'd0, stk_underflow}, 16'h0001);
        check("R9 pc held", pc, 16'h0102);
        @(negedge clk);
        check("R9 pulse one cycle", {15'd0, stk_underflow}, 16'h0000);

        // Fill the stack to 8 with the bench's own return model.
        here = 16'h0102;
        for (int i = 0; i < 8; i++) begin
            model[i] = here + 16'd2;
            here = 16'h1000 + 16'(i * 16);
            do_step(4'd7, 1'b1, 4'b0000, here);
            check($sformatf("R7 fill call %0d", i), pc, here);
        end

        // R8 ninth call refused.
        do_step(4'd7, 1'b1, 4'b0000, 16'h7777);
        check("R8 overflow pulse", {15'd0, stk_overflow}, 16'h0001);
        check("R8 pc held", pc, here);

        // Unwind: LIFO order, contents untouched by the refused call.
        for (int i = 7; i >= 0; i--) begin
            do_step(4'd8, 1'b0, 4'b0000, 16'hAAAA);
            check($sformatf("R7 unwind %0d", i), pc, model[i]);
        end
        check("R8 no error on unwind", {14'd0, stk_overflow, stk_underflow}, 16'h0000);

        // R10 halt, then further steps ignored.
        do_step(4'd9, 1'b0, 4'b0000, 16'h5555);
        check("R10 halted set", {15'd0, halted}, 16'h0001);
        check("R10 pc kept", pc, 16'h0104);
        do_step(4'd1, 1'b0, 4'b0000, 16'h5555);
        check("R10 jump ignored", pc, 16'h0104);
        do_step(4'd7, 1'b0, 4'b0000, 16'h5555);
        check("R10 call ignored", pc, 16'h0104);

        // R1 reset clears halt.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset pc", pc, 16'h0000);
        check("R1 reset halt", {15'd0, halted}, 16'h0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule